// File: doc/BRIEF.md
# Limit-Monitor Interrupt Controller

This block watches a stream of conversion results. Each result arrives with a channel index and a sample-valid strobe. The block compares each result with limits held for its channel. Voltage channels have an upper and a lower window edge. The last channel is a temperature channel with a single hot threshold. A failed comparison sets a sticky per-channel bit in a status register. Reading that register returns its contents and empties it.

The interrupt line is active-low and meant for a shared open-drain net. It is presented as a level `irq_no` together with a drive enable `irq_oe_o`. The line is driven low only while interrupts are enabled, the blocking bit is clear and some status bit is set. The blocking bit holds the line released; it does not acknowledge anything. A fault that persists sets its bit again at every conversion, even though each read clears it. The line therefore pulses once per conversion period for as long as the fault lasts.

Register map (word address, `DATA_W`-bit data):
- 0x00 is the control register. Bit 1 is the enable and bit 3 is the block bit; all other bits read 0.
- 0x01 is the status register. Bit c belongs to channel c, and a read clears it.
- 0x10+c is the upper limit of channel c. For the temperature channel this is the hot limit.
- 0x20+c is the lower limit of channel c.

Top module: `lim_irq_ctrl`

## Requirements
- R1: During and after reset, `irq_no`=1 and `irq_oe_o`=0. The control register and the status register read 0. Every upper limit reads all ones and every lower limit reads 0.
- R2: A voltage channel sets its status bit when the result is strictly above its upper limit (0x10+c). A result equal to the upper limit sets nothing.
- R3: A voltage channel sets its status bit when the result is less than or equal to its lower limit (0x20+c). A result one above the lower limit sets nothing.
- R4: The temperature channel (index `NUM_CH`-1) sets its bit only when the result is strictly above its hot limit (0x10+`NUM_CH`-1). A result equal to the hot limit, or a result of 0, sets nothing.
- R5: The line is driven (`irq_no`=0, `irq_oe_o`=1) exactly when control bit 1 is 1, control bit 3 is 0 and the status register is nonzero. It takes effect in the cycle after the clock edge that latches the sample or the control write.
- R6: A read of 0x01 returns the current status in the same cycle and clears it at the clock edge. The line is released from the next cycle on.
- R7: While a fault persists, each new valid sample on that channel sets the bit again and drives the line again. Status bits never clear except through a status read.
- R8: While control bit 3 is 1, the line stays released whatever the status holds, yet status bits still latch. Writing bit 3 back to 0 lets the pending status drive the line.
- R9: When a failing sample and a status read hit the same clock edge, the read returns the prior contents and the new bit survives the clear.
- R10: Results presented while `smp_valid_i`=0 change no status bit.
- R11: Limits read back as written. The control register keeps only bits 1 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Conversion result valid strobe |
| smp_ch_i | input | CH_W | Channel index of the result |
| smp_data_i | input | DATA_W | Conversion result |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears status at 0x01) |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, combinational from the address |
| irq_no | output | 1 | Interrupt level, low when active |
| irq_oe_o | output | 1 | Drive enable for the open-drain line |

## Verification
The assertions assume a sample strobe and a status read are single-cycle events aligned to the clock. They also assume a read strobe only clears status when its address is 0x01. Stimulus is driven on the falling edge and held for exactly one cycle, which meets both assumptions. Register writes and samples never overlap in the bench. The checker can therefore attribute every change in status to a sample or a read alone.

// File: rtl/lim_irq_pkg.sv
package lim_irq_pkg;
  localparam int unsigned ADDR_W      = 6;
  localparam int unsigned CFG_EN_BIT  = 1;
  localparam int unsigned CFG_CLR_BIT = 3;
  localparam logic [ADDR_W-1:0] ADDR_CFG     = 6'h00;
  localparam logic [ADDR_W-1:0] ADDR_STAT    = 6'h01;
  localparam logic [ADDR_W-1:0] ADDR_HI_BASE = 6'h10;
  localparam logic [ADDR_W-1:0] ADDR_LO_BASE = 6'h20;
endpackage

// File: rtl/lim_irq_regs.sv
module lim_irq_regs
  import lim_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              cfg_en_o,
  output logic              cfg_clr_o,
  output logic [DATA_W-1:0] hi_o [NUM_CH],
  output logic [DATA_W-1:0] lo_o [NUM_CH]
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_en_o  <= 1'b0;
      cfg_clr_o <= 1'b0;
      for (int c = 0; c < NUM_CH; c++) begin
        hi_o[c] <= '1;
        lo_o[c] <= '0;
      end
    end else if (wr_i) begin
      if (addr_i == ADDR_CFG) begin
        cfg_en_o  <= wdata_i[CFG_EN_BIT];
        cfg_clr_o <= wdata_i[CFG_CLR_BIT];
      end
      for (int c = 0; c < NUM_CH; c++) begin
        if (addr_i == ADDR_HI_BASE + ADDR_W'(c)) hi_o[c] <= wdata_i;
        if (addr_i == ADDR_LO_BASE + ADDR_W'(c)) lo_o[c] <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/lim_irq_cmp.sv
module lim_irq_cmp #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned DATA_W = 12,
  localparam int unsigned CH_W  = $clog2(NUM_CH),
  localparam int unsigned TEMP_CH = NUM_CH - 1
) (
  input  logic              valid_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] hi_i [NUM_CH],
  input  logic [DATA_W-1:0] lo_i [NUM_CH],
  output logic [NUM_CH-1:0] viol_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic flt;
    if (g == TEMP_CH) begin : g_temp
      assign flt = data_i > hi_i[g];
    end else begin : g_volt
      assign flt = (data_i > hi_i[g]) || (data_i <= lo_i[g]);
    end
    assign viol_o[g] = valid_i && (ch_i == CH_W'(g)) && flt;
  end
endmodule

// File: rtl/lim_irq_stat.sv
module lim_irq_stat #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] set_i,
  input  logic              clr_i,
  output logic [NUM_CH-1:0] stat_o
);
  // set beats clear-on-read in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    stat_o <= '0;
    else if (clr_i) stat_o <= set_i;
    else            stat_o <= stat_o | set_i;
  end
endmodule

// File: rtl/lim_irq_ctrl.sv
module lim_irq_ctrl
  import lim_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned DATA_W = 12,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_valid_i,
  input  logic [CH_W-1:0]   smp_ch_i,
  input  logic [DATA_W-1:0] smp_data_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_no,
  output logic              irq_oe_o
);
  logic              cfg_en, cfg_clr, rd_stat, irq_act;
  logic [DATA_W-1:0] hi_lim [NUM_CH];
  logic [DATA_W-1:0] lo_lim [NUM_CH];
  logic [NUM_CH-1:0] viol, stat_q;

  lim_irq_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) i_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .cfg_en_o(cfg_en), .cfg_clr_o(cfg_clr),
    .hi_o(hi_lim), .lo_o(lo_lim)
  );

  lim_irq_cmp #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) i_cmp (
    .valid_i(smp_valid_i), .ch_i(smp_ch_i), .data_i(smp_data_i),
    .hi_i(hi_lim), .lo_i(lo_lim), .viol_o(viol)
  );

  assign rd_stat = reg_rd_i && (reg_addr_i == ADDR_STAT);

  lim_irq_stat #(.NUM_CH(NUM_CH)) i_stat (
    .clk_i, .rst_ni, .set_i(viol), .clr_i(rd_stat), .stat_o(stat_q)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_CFG) begin
      reg_rdata_o[CFG_EN_BIT]  = cfg_en;
      reg_rdata_o[CFG_CLR_BIT] = cfg_clr;
    end else if (reg_addr_i == ADDR_STAT) begin
      reg_rdata_o = DATA_W'(stat_q);
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (reg_addr_i == ADDR_HI_BASE + ADDR_W'(c)) reg_rdata_o = hi_lim[c];
      if (reg_addr_i == ADDR_LO_BASE + ADDR_W'(c)) reg_rdata_o = lo_lim[c];
    end
  end

  // clear bit blocks the path, it does not acknowledge
  assign irq_act  = cfg_en && !cfg_clr && (|stat_q);
  assign irq_no   = !irq_act;
  assign irq_oe_o = irq_act;
endmodule

// File: rtl/lim_irq_ctrl_chk.sv
module lim_irq_ctrl_chk
  import lim_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              smp_valid_i,
  input logic              reg_rd_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              irq_no,
  input logic              irq_oe_o,
  input logic              cfg_en,
  input logic              cfg_clr,
  input logic [NUM_CH-1:0] stat_q
);
  logic rd_st;
  assign rd_st = reg_rd_i && (reg_addr_i == ADDR_STAT);

  always @(posedge clk_i) begin
    if (!rst_ni) assert_rst_released_R1: assert (irq_no && !irq_oe_o);
  end

  assert_drive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_en && !cfg_clr && (stat_q != '0)) |-> (!irq_no && irq_oe_o));

  assert_read_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_st && !smp_valid_i) |=> (stat_q == '0));

  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_st |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  assert_block_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_clr |-> (irq_no && !irq_oe_o));

  assert_idle_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!smp_valid_i && !rd_st) |=> $stable(stat_q));
endmodule

bind lim_irq_ctrl lim_irq_ctrl_chk #(.NUM_CH(NUM_CH)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .smp_valid_i(smp_valid_i),
  .reg_rd_i(reg_rd_i), .reg_addr_i(reg_addr_i),
  .irq_no(irq_no), .irq_oe_o(irq_oe_o),
  .cfg_en(cfg_en), .cfg_clr(cfg_clr), .stat_q(stat_q)
);

// File: tb/test_lim_irq_ctrl.sv
`timescale 1ns/1ps
module test_lim_irq_ctrl;
  localparam int NUM_CH = 8;
  localparam int DATA_W = 12;
  localparam int CH_W   = 3;
  localparam int AW     = 6;
  localparam int NV     = 12;
  // {expect bit set, channel, data}
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, 3'd0, 12'd101}, {1'b0, 3'd0, 12'd100}, {1'b0, 3'd0, 12'd21},
    {1'b1, 3'd0, 12'd20},  {1'b1, 3'd0, 12'd5},   {1'b0, 3'd0, 12'd50},
    {1'b1, 3'd7, 12'd81},  {1'b0, 3'd7, 12'd80},  {1'b0, 3'd7, 12'd0},
    {1'b0, 3'd3, 12'd4095},{1'b1, 3'd3, 12'd0},   {1'b0, 3'd3, 12'd1}
  };

  logic clk = 0, rst_n = 0;
  logic smp_valid = 0, reg_wr = 0, reg_rd = 0;
  logic [CH_W-1:0] smp_ch = '0;
  logic [DATA_W-1:0] smp_data = '0, reg_wdata = '0, reg_rdata;
  logic [AW-1:0] reg_addr = '0;
  logic irq_n, irq_oe;
  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  lim_irq_ctrl #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) i_lim_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(smp_valid), .smp_ch_i(smp_ch),
    .smp_data_i(smp_data), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_no(irq_n), .irq_oe_o(irq_oe)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_irq(string tag, bit active);
    check(tag, {30'd0, irq_n, irq_oe}, active ? 1 : 2);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DATA_W-1:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd_chk(string tag, logic [AW-1:0] a, int exp);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    #1 check(tag, int'(reg_rdata), exp);
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic samp(logic [CH_W-1:0] c, logic [DATA_W-1:0] d);
    @(negedge clk); smp_valid = 1; smp_ch = c; smp_data = d;
    @(negedge clk); smp_valid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk_irq("R1 irq in reset", 0);
    rst_n = 1;
    rd_chk("R1 cfg reset", 6'h00, 0);
    rd_chk("R1 status reset", 6'h01, 0);
    rd_chk("R1 hi reset", 6'h10, 'hFFF);
    rd_chk("R1 lo reset", 6'h20, 0);
    chk_irq("R1 irq after reset", 0);

    // R5: enable gates an already pending status
    samp(3'd0, 12'd0);
    chk_irq("R5 disabled", 0);
    wr(6'h00, 12'h002);
    chk_irq("R5 enabled pending", 1);
    rd_chk("R6 status read", 6'h01, 1);
    chk_irq("R6 released", 0);

    // R11 limit setup and readback
    wr(6'h10, 12'd100);
    wr(6'h20, 12'd20);
    wr(6'h17, 12'd80);
    rd_chk("R11 hi readback", 6'h10, 100);
    rd_chk("R11 hot readback", 6'h17, 80);
    wr(6'h00, 12'hFFF);
    rd_chk("R11 cfg mask", 6'h00, 'h00A);
    wr(6'h00, 12'h002);

    // R2 R3 R4 table
    for (int i = 0; i < NV; i++) begin
      automatic logic e = VEC[i][15];
      automatic int c = int'(VEC[i][14:12]);
      samp(VEC[i][14:12], VEC[i][11:0]);
      chk_irq($sformatf("R2/R3/R4 vec%0d irq", i), e);
      rd_chk($sformatf("R2/R3/R4 vec%0d status", i), 6'h01, e ? (1 << c) : 0);
      chk_irq($sformatf("R6 vec%0d release", i), 0);
    end

    // R7 persistent fault pulses
    samp(3'd0, 12'd200);
    chk_irq("R7 first", 1);
    rd_chk("R7 read", 6'h01, 1);
    chk_irq("R7 released", 0);
    samp(3'd0, 12'd200);
    chk_irq("R7 reasserted", 1);
    rd_chk("R7 read2", 6'h01, 1);

    // R8 block bit
    wr(6'h00, 12'h00A);
    samp(3'd0, 12'd200);
    chk_irq("R8 blocked", 0);
    wr(6'h00, 12'h002);
    chk_irq("R8 unblocked", 1);
    rd_chk("R8 status latched", 6'h01, 1);

    // R9 sample and read on same edge
    @(negedge clk);
    smp_valid = 1; smp_ch = 3'd7; smp_data = 12'd90;
    reg_rd = 1; reg_addr = 6'h01;
    #1 check("R9 old contents", int'(reg_rdata), 0);
    @(negedge clk); smp_valid = 0; reg_rd = 0;
    chk_irq("R9 bit survives", 1);
    rd_chk("R9 status", 6'h01, 'h80);

    // R10 invalid samples ignored
    @(negedge clk); smp_ch = 3'd0; smp_data = 12'd300;
    repeat (2) @(negedge clk);
    chk_irq("R10 irq", 0);
    rd_chk("R10 status", 6'h01, 0);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule